// File: doc/BRIEF.md
# Counted-Event Sequence Property Monitor

This block watches one temporal property on a running design and flags any trace that breaks it. An attempt opens on a cycle where the start input is high. From the next cycle on, the monitor counts acquire events until it has seen N of them. The events need not be back to back. The cancel input must stay low for the whole of this counting window. If cancel rises, the attempt is dropped with no obligation, and that is not an error. Once the N-th acquire arrives, an obligation begins on the following cycle. The monitor must see N release events, also possibly separated by idle cycles, before the terminate input shows up. Terminate arriving first is a violation.

The check is weak. An obligation still pending when the run stops is never reported. Only one attempt is tracked at a time. A start that arrives while an attempt is open is ignored and reported on a coverage pulse. The outcome pulses (violation, done, abort, overlap) are registered. Each appears in the cycle after the input cycle that decides it. Reset is synchronous and active high.

Top module: `seq_prop_monitor`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is 0.
- R2: A start sampled while no attempt is open opens one. An acquire sampled in that same start cycle is not counted.
- R3: The trigger matches on the cycle that samples the N-th counted acquire (default N=8). Any number of idle cycles may separate the acquires.
- R4: Cancel high on any acquire-window cycle drops the attempt and raises the abort output for exactly the next cycle. This holds even when acquire is high in that cycle. No violation follows, and a later terminate or release has no effect.
- R5: The obligation starts on the cycle after the match. A release or terminate sampled in the match cycle is neither counted nor a violation.
- R6: When the N-th release of the obligation is sampled, the done output is high for exactly the next cycle and the monitor returns to idle. Idle cycles may separate the releases.
- R7: Terminate sampled in an obligation cycle that does not bring the release count to N raises the violation pulse in the next cycle and sets the sticky violation flag.
- R8: A release and a terminate in the same obligation cycle count the release first. If that release is the N-th, the result is done and not a violation.
- R9: A start sampled while an attempt is in the acquire or obligation phase does not restart it. It raises the overlap output for the next cycle.
- R10: The violation pulse lasts one cycle. The sticky flag stays high until reset, including across later passing attempts.
- R11: A pending obligation with no terminate is never flagged, however long it waits.
- R12: Cancel has no effect during the obligation phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Opens an attempt |
| acq_i | input | 1 | Acquire event counted in the trigger window |
| cancel_i | input | 1 | Drops the attempt while acquiring |
| rel_i | input | 1 | Release event counted in the obligation |
| term_i | input | 1 | Terminate; fails a pending obligation |
| viol_sticky_o | output | 1 | Violation seen since reset |
| viol_pulse_o | output | 1 | One-cycle violation pulse |
| done_pulse_o | output | 1 | One-cycle pulse when an obligation is met |
| abort_pulse_o | output | 1 | One-cycle pulse when cancel drops an attempt |
| overlap_o | output | 1 | One-cycle pulse for an ignored start |

## Verification
Acquires and releases are applied with idle gaps between them. Acquire is also driven in the start cycle, and release with terminate in the match cycle, so that a counter starting one cycle early shows up as a done one cycle early. A release paired with terminate at the final count tells release-first ordering apart from terminate-first ordering. A cancel sampled together with an acquire tells cancel priority apart from acquire priority. Further runs apply a start during each active phase, a cancel during the obligation, and a long wait with an obligation pending; these respectively separate dropped starts from restarts, cancel-is-ignored from cancel-aborts, and weak semantics from a timeout.

// File: rtl/mon_pkg.sv
package mon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_OBL  = 2'd2,
    ST_DONE = 2'd3
  } mon_state_e;

  // bits needed to hold the values 0..n
  function automatic int count_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int LIMIT_N = 8,
  parameter int CW      = mon_pkg::count_bits(LIMIT_N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          hit
);

  localparam logic [CW-1:0] LIMIT = CW'(LIMIT_N);

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c, input logic en);
    return (c == LIMIT) ? c : c + CW'(en);
  endfunction

  // hit: this cycle's event brings the count to the limit
  assign hit = inc && (bump(cnt, inc) == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= bump(cnt, inc);
  end

endmodule

// File: rtl/mon_fsm.sv
module mon_fsm
  import mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       cancel_i,
  input  logic       term_i,
  input  logic       acq_hit,
  input  logic       rel_hit,
  output mon_state_e state,
  output logic       ev_open,
  output logic       ev_abort,
  output logic       ev_viol,
  output logic       ev_overlap
);

  mon_state_e state_nx;
  logic       active;

  assign active = (state == ST_ACQ) || (state == ST_OBL);

  always_comb begin
    state_nx   = state;
    ev_open    = 1'b0;
    ev_abort   = 1'b0;
    ev_viol    = 1'b0;
    ev_overlap = start_i && active;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_nx = ST_ACQ;
          ev_open  = 1'b1;
        end else begin
          state_nx = ST_IDLE;
        end
      end
      ST_ACQ: begin
        if (cancel_i) begin
          state_nx = ST_IDLE;
          ev_abort = 1'b1;
        end else if (acq_hit) begin
          state_nx = ST_OBL;
        end
      end
      ST_OBL: begin
        if (rel_hit) begin
          state_nx = ST_DONE;
        end else if (term_i) begin
          state_nx = ST_IDLE;
          ev_viol  = 1'b1;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

endmodule

// File: rtl/mon_flags.sv
module mon_flags (
  input  logic clk,
  input  logic rst,
  input  logic ev_viol,
  input  logic ev_abort,
  input  logic ev_overlap,
  output logic viol_sticky,
  output logic viol_pulse,
  output logic abort_pulse,
  output logic overlap_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_sticky   <= 1'b0;
      viol_pulse    <= 1'b0;
      abort_pulse   <= 1'b0;
      overlap_pulse <= 1'b0;
    end else begin
      viol_sticky   <= viol_sticky | ev_viol;
      viol_pulse    <= ev_viol;
      abort_pulse   <= ev_abort;
      overlap_pulse <= ev_overlap;
    end
  end

endmodule

// File: rtl/seq_prop_monitor.sv
module seq_prop_monitor
  import mon_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic acq_i,
  input  logic cancel_i,
  input  logic rel_i,
  input  logic term_i,
  output logic viol_sticky_o,
  output logic viol_pulse_o,
  output logic done_pulse_o,
  output logic abort_pulse_o,
  output logic overlap_o
);

  localparam int CW = count_bits(N);

  mon_state_e    state;
  logic [CW-1:0] acq_cnt;
  logic [CW-1:0] rel_cnt;
  logic          acq_inc, rel_inc;
  logic          acq_hit, rel_hit;
  logic          ev_open, ev_abort, ev_viol, ev_overlap;

  // counted events: acquire only while guarded by a low cancel
  assign acq_inc = (state == ST_ACQ) && acq_i && !cancel_i;
  assign rel_inc = (state == ST_OBL) && rel_i;

  evt_counter #(.LIMIT_N(N), .CW(CW)) u_acq_cnt (
    .clk (clk),
    .rst (rst),
    .clr (state != ST_ACQ),
    .inc (acq_inc),
    .cnt (acq_cnt),
    .hit (acq_hit)
  );

  evt_counter #(.LIMIT_N(N), .CW(CW)) u_rel_cnt (
    .clk (clk),
    .rst (rst),
    .clr (state != ST_OBL),
    .inc (rel_inc),
    .cnt (rel_cnt),
    .hit (rel_hit)
  );

  mon_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .cancel_i   (cancel_i),
    .term_i     (term_i),
    .acq_hit    (acq_hit),
    .rel_hit    (rel_hit),
    .state      (state),
    .ev_open    (ev_open),
    .ev_abort   (ev_abort),
    .ev_viol    (ev_viol),
    .ev_overlap (ev_overlap)
  );

  mon_flags u_flags (
    .clk           (clk),
    .rst           (rst),
    .ev_viol       (ev_viol),
    .ev_abort      (ev_abort),
    .ev_overlap    (ev_overlap),
    .viol_sticky   (viol_sticky_o),
    .viol_pulse    (viol_pulse_o),
    .abort_pulse   (abort_pulse_o),
    .overlap_pulse (overlap_o)
  );

  assign done_pulse_o = (state == ST_DONE);

endmodule

// File: rtl/mon_checker.sv
module mon_checker
  import mon_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = count_bits(N)
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          acq_i,
  input logic          cancel_i,
  input logic          rel_i,
  input logic          term_i,
  input logic          viol_sticky_o,
  input logic          viol_pulse_o,
  input logic          done_pulse_o,
  input logic          abort_pulse_o,
  input logic          overlap_o,
  input mon_state_e    state,
  input logic [CW-1:0] acq_cnt,
  input logic [CW-1:0] rel_cnt
);

  localparam logic [CW-1:0] LIMIT = CW'(N);

  AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (rst)
    viol_sticky_o |=> viol_sticky_o); // R10
  AST_PULSE_IN_STICKY: assert property (@(posedge clk) disable iff (rst)
    viol_pulse_o |-> viol_sticky_o); // R7
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    viol_pulse_o |=> !viol_pulse_o); // R10
  AST_VIOL_AFTER_TERM: assert property (@(posedge clk) disable iff (rst)
    viol_pulse_o |-> $past(term_i)); // R7
  AST_ABORT_AFTER_CANCEL: assert property (@(posedge clk) disable iff (rst)
    abort_pulse_o |-> $past(cancel_i)); // R4
  AST_DONE_AFTER_REL: assert property (@(posedge clk) disable iff (rst)
    done_pulse_o |-> $past(rel_i)); // R6
  AST_OUTCOMES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({viol_pulse_o, done_pulse_o, abort_pulse_o})); // R4
  AST_OVERLAP_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    overlap_o |-> $past(start_i)); // R9
  AST_ACQ_BOUND: assert property (@(posedge clk) disable iff (rst)
    acq_cnt <= LIMIT); // R3
  AST_REL_BOUND: assert property (@(posedge clk) disable iff (rst)
    rel_cnt <= LIMIT); // R6
  AST_ACQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACQ && acq_i && !cancel_i && acq_cnt < LIMIT - 1'b1)
      |=> (acq_cnt == $past(acq_cnt) + 1'b1)); // R3
  AST_OBL_IGNORES_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OBL && cancel_i && !term_i && !start_i) |=> !abort_pulse_o && !viol_pulse_o); // R12

endmodule

bind seq_prop_monitor mon_checker #(.N(N)) u_mon_checker (
  .clk           (clk),
  .rst           (rst),
  .start_i       (start_i),
  .acq_i         (acq_i),
  .cancel_i      (cancel_i),
  .rel_i         (rel_i),
  .term_i        (term_i),
  .viol_sticky_o (viol_sticky_o),
  .viol_pulse_o  (viol_pulse_o),
  .done_pulse_o  (done_pulse_o),
  .abort_pulse_o (abort_pulse_o),
  .overlap_o     (overlap_o),
  .state         (state),
  .acq_cnt       (acq_cnt),
  .rel_cnt       (rel_cnt)
);

// File: tb/test_seq_prop_monitor.sv
`timescale 1ns/1ps
module test_seq_prop_monitor;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, acq_i = 0, cancel_i = 0, rel_i = 0, term_i = 0;
  logic viol_sticky_o, viol_pulse_o, done_pulse_o, abort_pulse_o, overlap_o;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  seq_prop_monitor #(.N(N)) i_seq_prop_monitor (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .acq_i         (acq_i),
    .cancel_i      (cancel_i),
    .rel_i         (rel_i),
    .term_i        (term_i),
    .viol_sticky_o (viol_sticky_o),
    .viol_pulse_o  (viol_pulse_o),
    .done_pulse_o  (done_pulse_o),
    .abort_pulse_o (abort_pulse_o),
    .overlap_o     (overlap_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // apply one cycle of inputs; outputs afterwards show that cycle's outcome
  task automatic cyc(input logic s, input logic a, input logic c, input logic r, input logic t);
    start_i = s; acq_i = a; cancel_i = c; rel_i = r; term_i = t;
    @(posedge clk);
    #1;
    start_i = 0; acq_i = 0; cancel_i = 0; rel_i = 0; term_i = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  // start plus N acquires, one idle cycle between each
  task automatic open_and_match();
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < N; i++) begin
      cyc(0, 1, 0, 0, 0);
      if (i != N - 1) cyc(0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "sticky in reset", viol_sticky_o, 1'b0);
    chk("R1", "viol in reset",   viol_pulse_o,  1'b0);
    chk("R1", "done in reset",   done_pulse_o,  1'b0);
    chk("R1", "abort in reset",  abort_pulse_o, 1'b0);
    chk("R1", "overlap in reset", overlap_o,    1'b0);
    rst = 1'b0;
    cyc(0, 0, 0, 0, 0);
    chk("R1", "sticky after reset", viol_sticky_o, 1'b0);
    chk("R1", "done after reset",   done_pulse_o,  1'b0);
  endtask

  task automatic t_pass_with_gaps();
    logic early;
    early = 1'b0;
    cyc(1, 1, 0, 0, 0);                 // R2: acquire here not counted
    for (int i = 0; i < N - 1; i++) begin
      cyc(0, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
    end
    cyc(0, 1, 0, 1, 1);                 // R3 match; R5 rel/term ignored
    chk("R5", "no violation on match cycle", viol_pulse_o, 1'b0);
    for (int i = 0; i < N - 1; i++) begin
      cyc(0, 0, 0, 1, 0);
      if (done_pulse_o) early = 1'b1;
      cyc(0, 0, 0, 0, 0);
      if (done_pulse_o) early = 1'b1;
    end
    chk("R2", "no early done (start-cycle acquire not counted)", early, 1'b0);
    cyc(0, 0, 0, 1, 1);                 // R8 N-th release with terminate
    chk("R6", "done after N-th release", done_pulse_o, 1'b1);
    chk("R8", "release before terminate: no violation", viol_pulse_o, 1'b0);
    cyc(0, 0, 0, 0, 0);
    chk("R6", "done lasts one cycle", done_pulse_o, 1'b0);
    chk("R8", "sticky stays low", viol_sticky_o, 1'b0);
  endtask

  task automatic t_cancel();
    logic any;
    any = 1'b0;
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0);
    cyc(0, 1, 1, 0, 0);                 // cancel together with acquire
    chk("R4", "abort after cancel", abort_pulse_o, 1'b1);
    chk("R4", "no violation on cancel", viol_pulse_o, 1'b0);
    cyc(0, 0, 0, 0, 1);
    chk("R4", "abort one cycle", abort_pulse_o, 1'b0);
    chk("R4", "terminate after drop ignored", viol_pulse_o, 1'b0);
    for (int i = 0; i < N; i++) cyc(0, 1, 0, 0, 0);
    for (int i = 0; i < N; i++) begin
      cyc(0, 0, 0, 1, 1);
      if (done_pulse_o || viol_pulse_o) any = 1'b1;
    end
    chk("R4", "dropped attempt leaves no obligation", any, 1'b0);
    chk("R4", "sticky low after drop", viol_sticky_o, 1'b0);
  endtask

  task automatic t_overlap_and_violation();
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);                 // start ignored, acquire #1 counted
    chk("R9", "overlap in acquire phase", overlap_o, 1'b1);
    for (int i = 0; i < N - 1; i++) cyc(0, 1, 0, 0, 0);
    chk("R9", "overlap one cycle", overlap_o, 1'b0);
    cyc(1, 0, 0, 1, 0);                 // start during obligation, release 1
    chk("R9", "overlap in obligation phase", overlap_o, 1'b1);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R7", "violation pulse on early terminate", viol_pulse_o, 1'b1);
    chk("R7", "sticky set", viol_sticky_o, 1'b1);
    cyc(0, 0, 0, 0, 0);
    chk("R10", "violation pulse one cycle", viol_pulse_o, 1'b0);
    chk("R10", "sticky held", viol_sticky_o, 1'b1);
  endtask

  task automatic t_cancel_in_obligation();
    open_and_match();
    for (int i = 0; i < N - 1; i++) cyc(0, 0, 1, 1, 0);
    chk("R12", "no abort from cancel in obligation", abort_pulse_o, 1'b0);
    cyc(0, 0, 1, 1, 0);
    chk("R12", "obligation completes despite cancel", done_pulse_o, 1'b1);
    chk("R10", "sticky survives passing attempt", viol_sticky_o, 1'b1);
  endtask

  task automatic t_weak_pending();
    logic any;
    any = 1'b0;
    do_reset();
    chk("R10", "sticky cleared by reset", viol_sticky_o, 1'b0);
    open_and_match();
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0);
    for (int i = 0; i < 40; i++) begin
      cyc(0, 0, 0, 0, 0);
      if (viol_pulse_o || done_pulse_o || viol_sticky_o) any = 1'b1;
    end
    chk("R11", "pending obligation not flagged", any, 1'b0);
    cyc(0, 0, 0, 0, 1);
    chk("R11", "terminate still fails pending obligation", viol_pulse_o, 1'b1);
  endtask

  initial begin
    t_reset();
    t_pass_with_gaps();
    t_cancel();
    t_overlap_and_violation();
    t_cancel_in_obligation();
    t_weak_pending();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule